// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block is the host-side sequencer for an external 12-bit successive-approximation converter. The converter has three pins: a start line, a serial clock and a serial data line. A one-cycle request runs a full conversion. The controller drives the start line with the pattern that selects the wanted input mode, holds the line for the acquisition window, and then drops it to begin the conversion. It waits for the worst-case conversion time and reads the result with an idle-low serial clock, sampling the data line on each rising edge.

The alternate mode is the second channel on the single-ended variant, or bipolar input on the differential variant. It is chosen by an extra short high-low pulse on the start line before the acquisition phase. No command word is sent. Every time window is a count of system-clock cycles, derived from the clock frequency parameter. The read length can be 12 or 16 serial clocks. Fewer than 12 is never issued, because a short read would silently switch the next conversion into the alternate mode. The 12-bit result is returned as a 16-bit word with a one-cycle valid strobe. It is sign-extended when the alternate (bipolar) mode was requested and zero-extended otherwise.

The state machine has eight states. ST_IDLE goes to ST_PRE_HI when an alternate-mode request is accepted, and to ST_ACQ for a normal request. ST_PRE_HI goes to ST_PRE_LO, and ST_PRE_LO goes to ST_ACQ; each of these lasts PULSE_CYC cycles. ST_ACQ goes to ST_CONV after ACQ_CYC cycles. ST_CONV goes to ST_SCK_LO after CONV_CYC cycles. ST_SCK_LO goes to ST_SCK_HI after SCLK_HALF cycles. ST_SCK_HI goes back to ST_SCK_LO after SCLK_HALF cycles, or to ST_DONE once the last bit has been taken. ST_DONE goes to ST_IDLE after one cycle.

Top module: `sadc_read_ctrl`

## Requirements
- R1: After reset and whenever no request is in progress, busy_o, cnv_o, sclk_o and valid_o are all 0.
- R2: A request with sel_alt_i=0, taken in idle, raises cnv_o on the next clock and holds it high for at least ACQ_CYC cycles (1.4 us) before it falls to start the conversion.
- R3: A request with sel_alt_i=1 first drives cnv_o high for at least PULSE_CYC cycles (30 ns), then low for at least PULSE_CYC cycles, then high for the R2 acquisition window.
- R4: After cnv_o falls to start a conversion, the first rising edge of sclk_o comes no earlier than CONV_CYC cycles (3.7 us) later.
- R5: sclk_o idles low. Each high phase and each low phase lasts at least SCLK_HALF cycles. sdo_i is sampled on each rising edge, MSB first.
- R6: Each conversion is followed by exactly max(READ_BITS,12) rising edges of sclk_o. This is 16 by default. At least 12 edges always come before cnv_o rises again.
- R7: Only the first 12 bits sampled form the result. Bits sampled after the twelfth do not affect result_o.
- R8: result_o[11:0] holds the 12 sampled bits with the first bit at bit 11. result_o[15:12] copies bit 11 when the request had sel_alt_i=1, and is 0 otherwise.
- R9: valid_o is high for exactly one cycle, in the same cycle result_o takes its new value. result_o then holds until the next valid_o. busy_o is high from the cycle after the request through the valid_o cycle.
- R10: A request while busy_o is high is ignored. It does not change the mode of the conversion in progress, and it starts no conversion after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle conversion request |
| sel_alt_i | input | 1 | Mode select with the request: 1 = second channel / bipolar |
| sdo_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Conversion in progress |
| cnv_o | output | 1 | Conversion-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idle low |
| valid_o | output | 1 | One-cycle strobe, result_o is new |
| result_o | output | 16 | Extended 12-bit conversion result |

## Verification
The hardest situation to create from the ports is a request that lands while a conversion is already running, especially in the final ST_DONE cycle, where busy_o falls on the very next clock. The stimulus injects requests with the opposite mode select on randomly chosen cycles throughout each conversion, including the valid_o cycle. After each conversion the bench confirms three things: the decoded mode still matches the original request, the start line stays low, and busy_o stays low. A pin-level converter model decodes the mode from the measured start-line pulse widths. It feeds random bits past the twelfth edge, so any leak of those bits into the result shows up.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_ACQ,
        ST_CONV,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_DONE
    } sadc_state_e;

    // Round a duration in ns up to whole cycles of a clock given in MHz.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sadc_phase_timer.sv
module sadc_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] limit_i,
    output logic          done_o
);

    logic [TW-1:0] cnt_q;

    // Restarts at every state change; done in the last cycle of a phase.
    assign done_o = (cnt_q == limit_i - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
    parameter int RES_W = 12,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             sdo_i,
    output logic [RES_W-1:0] data_o,
    output logic [CW-1:0]    count_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            count_o <= '0;
        end else if (clear_i) begin
            data_o  <= '0;
            count_o <= '0;
        end else if (shift_i) begin
            // Bits past the result width are counted but not stored.
            if (count_o < CW'(RES_W)) begin
                data_o <= {data_o[RES_W-2:0], sdo_i};
            end
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/sadc_read_ctrl.sv
module sadc_read_ctrl
    import sadc_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int PULSE_CYC  = ns_to_cyc(30, CLK_MHZ),
    parameter int ACQ_CYC    = ns_to_cyc(1400, CLK_MHZ),
    parameter int CONV_CYC   = ns_to_cyc(3700, CLK_MHZ),
    parameter int SCLK_HALF  = ns_to_cyc(63, CLK_MHZ),
    parameter int READ_BITS  = 16,
    parameter int ALT_SIGNED = 1,
    parameter int RES_W      = 12,
    parameter int OUT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             sel_alt_i,
    input  logic             sdo_i,
    output logic             busy_o,
    output logic             cnv_o,
    output logic             sclk_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] result_o
);

    localparam int EFF_BITS = (READ_BITS < RES_W) ? RES_W : READ_BITS;
    localparam int CW       = $clog2(EFF_BITS + 1);
    localparam int MAXL     = max2(max2(PULSE_CYC, ACQ_CYC), max2(CONV_CYC, SCLK_HALF));
    localparam int TW       = $clog2(MAXL + 1);
    localparam int PAD      = OUT_W - RES_W;

    sadc_state_e      state_q, nxt;
    logic             alt_q;
    logic [TW-1:0]    limit;
    logic             t_done;
    logic             cap_en;
    logic [RES_W-1:0] cap_data;
    logic [CW-1:0]    cap_cnt;
    logic [OUT_W-1:0] ext_w;

    always_comb begin
        unique case (state_q)
            ST_PRE_HI, ST_PRE_LO:   limit = TW'(PULSE_CYC);
            ST_ACQ:                 limit = TW'(ACQ_CYC);
            ST_CONV:                limit = TW'(CONV_CYC);
            ST_SCK_LO, ST_SCK_HI:   limit = TW'(SCLK_HALF);
            default:                limit = TW'(1);
        endcase
    end

    sadc_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (nxt != state_q),
        .limit_i (limit),
        .done_o  (t_done)
    );

    // Sample on the same edge that raises sclk_o.
    assign cap_en = (state_q == ST_SCK_LO) && t_done;

    sadc_capture #(.RES_W(RES_W), .CW(CW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q == ST_CONV),
        .shift_i (cap_en),
        .sdo_i   (sdo_i),
        .data_o  (cap_data),
        .count_o (cap_cnt)
    );

    generate
        if (ALT_SIGNED != 0) begin : g_sext
            assign ext_w = alt_q ? {{PAD{cap_data[RES_W-1]}}, cap_data}
                                 : {{PAD{1'b0}}, cap_data};
        end else begin : g_zext
            assign ext_w = {{PAD{1'b0}}, cap_data};
        end
    endgenerate

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) nxt = sel_alt_i ? ST_PRE_HI : ST_ACQ;
            ST_PRE_HI: if (t_done) nxt = ST_PRE_LO;
            ST_PRE_LO: if (t_done) nxt = ST_ACQ;
            ST_ACQ:    if (t_done) nxt = ST_CONV;
            ST_CONV:   if (t_done) nxt = ST_SCK_LO;
            ST_SCK_LO: if (t_done) nxt = ST_SCK_HI;
            ST_SCK_HI: if (t_done) nxt = (cap_cnt == CW'(EFF_BITS)) ? ST_DONE : ST_SCK_LO;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            alt_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            if (state_q == ST_IDLE && req_i) alt_q <= sel_alt_i;
        end
    end

    // Registered outputs decoded from the next state: glitch-free pins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            cnv_o    <= 1'b0;
            sclk_o   <= 1'b0;
            valid_o  <= 1'b0;
            result_o <= '0;
        end else begin
            busy_o  <= (nxt != ST_IDLE);
            cnv_o   <= (nxt == ST_PRE_HI) || (nxt == ST_ACQ);
            sclk_o  <= (nxt == ST_SCK_HI);
            valid_o <= (nxt == ST_DONE);
            if (nxt == ST_DONE && state_q != ST_DONE) result_o <= ext_w;
        end
    end

endmodule

// File: rtl/sadc_read_ctrl_chk.sv
module sadc_read_ctrl_chk #(
    parameter int PULSE_CYC = 2,
    parameter int ACQ_CYC   = 70,
    parameter int CONV_CYC  = 185,
    parameter int RES_W     = 12
) (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic busy_o,
    input logic cnv_o,
    input logic sclk_o,
    input logic valid_o
);

    logic [15:0] hi_run, lo_run;
    logic [7:0]  edge_cnt;
    logic        cnv_d, sclk_d, conv_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run    <= '0;
            lo_run    <= '0;
            edge_cnt  <= '0;
            cnv_d     <= 1'b0;
            sclk_d    <= 1'b0;
            conv_seen <= 1'b0;
        end else begin
            cnv_d  <= cnv_o;
            sclk_d <= sclk_o;
            if (cnv_o) begin
                hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1;
                lo_run <= '0;
            end else begin
                lo_run <= (lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1;
                hi_run <= '0;
            end
            if (cnv_o) edge_cnt <= '0;
            else if (sclk_o && !sclk_d && edge_cnt != 8'hFF) edge_cnt <= edge_cnt + 1'b1;
            if (!cnv_o && cnv_d && hi_run >= 16'(ACQ_CYC)) conv_seen <= 1'b1;
            else if (cnv_o && !cnv_d) conv_seen <= 1'b0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cnv_o && !sclk_o && !valid_o));

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_o) |-> (hi_run >= 16'(PULSE_CYC)));

    p_conv_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && edge_cnt == 8'd0) |-> (lo_run >= 16'(CONV_CYC)));

    p_sclk_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cnv_o);

    p_min_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cnv_o) && conv_seen) |-> (edge_cnt >= 8'(RES_W)));

    p_valid_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i && !valid_o) |=> busy_o);

endmodule

bind sadc_read_ctrl sadc_read_ctrl_chk #(
    .PULSE_CYC (PULSE_CYC),
    .ACQ_CYC   (ACQ_CYC),
    .CONV_CYC  (CONV_CYC),
    .RES_W     (RES_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .busy_o  (busy_o),
    .cnv_o   (cnv_o),
    .sclk_o  (sclk_o),
    .valid_o (valid_o)
);

// File: tb/sadc_read_ctrl_tb.sv
module sadc_read_ctrl_tb;

    localparam int MHZ   = 50;
    localparam int PULSE = (30 * MHZ + 999) / 1000;
    localparam int ACQ   = (1400 * MHZ + 999) / 1000;
    localparam int CONV  = (3700 * MHZ + 999) / 1000;
    localparam int HALF  = (63 * MHZ + 999) / 1000;
    localparam int NBITS = 16;
    localparam int NTX   = 40;

    logic        clk = 1'b0;
    logic        rst_n, req_i, sel_alt_i, sdo_i;
    logic        busy_o, cnv_o, sclk_o, valid_o;
    logic [15:0] result_o;

    always #10 clk = ~clk;

    sadc_read_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_alt_i(sel_alt_i), .sdo_i(sdo_i),
        .busy_o(busy_o), .cnv_o(cnv_o), .sclk_o(sclk_o), .valid_o(valid_o), .result_o(result_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_result(input logic [11:0] w, input bit alt);
        return alt ? {{4{w[11]}}, w} : {4'h0, w};
    endfunction

    // Pin-level converter model state.
    logic [11:0] word;
    int   bitidx = 0, nconv = 0, edges = 0;
    int   hi_run = 0, lo_run = 0, sh_run = 0, sl_run = 0;
    bit   cnv_d = 0, sclk_d = 0, short_seen = 0, mode_seen = 0, conv_active = 0;
    bit   exp_alt = 0;

    function automatic logic [11:0] pick_word(input int n);
        case (n)
            0: return 12'h000;  1: return 12'hFFF;
            2: return 12'h800;  3: return 12'h7FF;
            4: return 12'h001;  5: return 12'hFFE;
            6: return 12'h555;  7: return 12'hAAA;
            default: return 12'($urandom);
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (cnv_o && !cnv_d) begin
                if (conv_active) chk(edges >= 12, "R6", "edges before restart", edges, 12);
                if (short_seen) chk(lo_run >= PULSE, "R3", "select low phase", lo_run, PULSE);
                conv_active = 0;
            end
            if (!cnv_o && cnv_d) begin
                if (hi_run >= ACQ) begin
                    chk(1, "R2", "acquisition window", hi_run, ACQ);
                    mode_seen = short_seen;
                    short_seen = 0;
                    word = pick_word(nconv);
                    nconv++;
                    bitidx = 0;
                    edges = 0;
                    sdo_i = word[11];
                    conv_active = 1;
                end else begin
                    chk(hi_run >= PULSE, "R3", "select high phase", hi_run, PULSE);
                    chk(!short_seen, "R2", "acquisition too short", hi_run, ACQ);
                    short_seen = 1;
                end
            end
            if (sclk_o && !sclk_d) begin
                chk(conv_active, "R4", "sclk without conversion", 0, 1);
                if (edges == 0) chk(lo_run >= CONV, "R4", "conversion wait", lo_run, CONV);
                else chk(sl_run >= HALF, "R5", "sclk low phase", sl_run, HALF);
                edges++;
            end
            if (!sclk_o && sclk_d) begin
                chk(sh_run >= HALF, "R5", "sclk high phase", sh_run, HALF);
                bitidx++;
                sdo_i = (bitidx < 12) ? word[11 - bitidx] : 1'($urandom);
            end
            if (valid_o) begin
                chk(mode_seen == exp_alt, "R3", "decoded mode", int'(mode_seen), int'(exp_alt));
                chk(edges == NBITS, "R6", "edges per read", edges, NBITS);
                chk(result_o[11:0] == word, "R7", "low 12 bits", result_o, word);
                chk(result_o == exp_result(word, exp_alt), "R8", "extended result",
                    result_o, exp_result(word, exp_alt));
            end
            hi_run = (cnv_o && cnv_d) ? hi_run + 1 : (cnv_o ? 1 : 0);
            lo_run = (!cnv_o && !cnv_d) ? lo_run + 1 : (!cnv_o ? 1 : 0);
            sh_run = (sclk_o && sclk_d) ? sh_run + 1 : (sclk_o ? 1 : 0);
            sl_run = (!sclk_o && !sclk_d) ? sl_run + 1 : (!sclk_o ? 1 : 0);
            cnv_d  = cnv_o;
            sclk_d = sclk_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5ADC));
        rst_n = 1'b0; req_i = 1'b0; sel_alt_i = 1'b0; sdo_i = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy_o, cnv_o, sclk_o, valid_o} == 4'b0, "R1", "reset outputs",
            {busy_o, cnv_o, sclk_o, valid_o}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk({busy_o, cnv_o, sclk_o} == 3'b0, "R1", "idle outputs", {busy_o, cnv_o, sclk_o}, 0);

        for (int t = 0; t < NTX; t++) begin
            logic [15:0] held;
            int guard;
            bit alt;
            alt = (t < 16) ? t[0] : 1'($urandom);
            exp_alt = alt;
            req_i = 1'b1; sel_alt_i = alt;
            @(negedge clk);
            req_i = 1'b0;
            chk(busy_o, "R9", "busy after request", busy_o, 1);
            chk(cnv_o, "R2", "start line raised", cnv_o, 1);
            guard = 0;
            while (!valid_o && guard < 2000) begin
                @(negedge clk);
                guard++;
                if (busy_o && ($urandom % 40 == 0 || (valid_o && t[1]))) begin
                    req_i = 1'b1; sel_alt_i = ~alt;
                end else begin
                    req_i = 1'b0;
                end
            end
            chk(valid_o, "R9", "valid reached", valid_o, 1);
            held = result_o;
            @(negedge clk);
            req_i = 1'b0;
            chk(!valid_o, "R9", "valid one cycle", valid_o, 0);
            chk(!busy_o, "R9", "busy released", busy_o, 0);
            repeat (4) @(negedge clk);
            chk(!busy_o && !cnv_o, "R10", "busy-time request ignored", {busy_o, cnv_o}, 0);
            chk(result_o == held, "R9", "result held", result_o, held);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule